// File: doc/BRIEF.md
# CAN Test-Mode Register and Pin Control

This block is the test register of a CAN controller and the logic that sits between the controller's protocol core and the two bus pins. On the transmit side a multiplexer chooses what reaches the transmit pin. It can pass the core's own bit stream, show the bit-timing sample point, or force the bus dominant or recessive. On the receive side the pin is brought into the clock domain through a synchronizer. The synchronized level is visible to software on reads and is fed to the core. When internal loopback is on, the core's own transmit bit goes back to the core's receive input instead of the pin level.

Software reaches the register through a simple word-wide bus write and read port at a fixed address. Writes are accepted only while an external test-enable input is high. Dropping test-enable returns both writable fields to their reset values, so the controller leaves every test mode as soon as test access is withdrawn.

Top module: `can_test_reg`

## Requirements
- R1: After reset the loopback field and the transmit-select field read as 0, and the transmit pin carries the core transmit bit.
- R2: A read at byte address 0x10 returns loopback in bit 4, transmit select in bits 6:5 and the synchronized receive level in bit 7, and zero in every other bit. A read at any other address returns all zeros.
- R3: A write made while test-enable is 0 loads nothing.
- R4: At the first clock edge where test-enable is 0, loopback and transmit select both return to 0.
- R5: With transmit select 0, the transmit pin equals the core transmit bit one clock later.
- R6: With transmit select 1, the transmit pin is 0 (dominant) in the clock after a sample-point pulse and 1 (recessive) otherwise.
- R7: Transmit select 2 drives the transmit pin to 0 and select 3 drives it to 1, one clock after the select is loaded, whatever the core transmit bit is.
- R8: Read bit 7 follows the receive pin two clocks later, with 0 meaning dominant and 1 meaning recessive.
- R9: With loopback set, the core receive input equals the core transmit bit. With loopback clear, it equals the synchronized receive pin level.
- R10: Write data bits other than 6:4 have no effect, and a write to an address other than 0x10 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testEn | input | 1 | External test access enable |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | 8 | Bus byte address |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data (combinational) |
| coreTx | input | 1 | Transmit bit from the protocol core |
| samplePt | input | 1 | One-clock sample-point pulse from bit timing |
| rxPin | input | 1 | Receive pin from the bus transceiver |
| txPin | output | 1 | Transmit pin to the bus transceiver |
| coreRx | output | 1 | Receive bit to the protocol core |

## Verification
The bench checks that a write made with test-enable low is dropped, and that a low test-enable wipes fields that were set earlier. A design that gated only on the address would keep stale test modes or accept forbidden writes. It writes all-ones and all-ones-except-fields patterns to catch a field placed at the wrong bit position or a reserved bit that leaks into the read data. It also writes to a neighbouring address, where a loose address decode would corrupt the register. For the pin paths it counts clocks. It checks that receive changes appear exactly two clocks late, that the sample-point dominant lasts one clock, and that loopback swaps the core receive source without disturbing the transmit pin. A missing or extra flop, or a wrong mux select, would shift or invert these observations.

// File: rtl/can_test_pkg.sv
package can_test_pkg;

  typedef enum logic [1:0] {
    TX_CORE   = 2'd0,
    TX_SAMPLE = 2'd1,
    TX_DOM    = 2'd2,
    TX_REC    = 2'd3
  } txSel_e;

  typedef struct packed {
    logic   clrAll;
    logic   load;
    logic   newLoop;
    txSel_e newTx;
  } regStrobe_t;

endpackage

// File: rtl/can_test_ctrl.sv
module can_test_ctrl
  import can_test_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
  parameter int LOOP_BIT  = 4,
  parameter int TXSEL_LSB = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output regStrobe_t        strb,
  output logic              rdHit
);

  logic addrHit;
  logic unusedWrBits;

  assign addrHit      = (busAddr == REG_ADDR);
  assign rdHit        = addrHit;
  assign unusedWrBits = ^busWrData;

  always_comb begin
    strb.clrAll  = ~testEn;
    strb.load    = testEn & busWrEn & addrHit;
    strb.newLoop = busWrData[LOOP_BIT];
    strb.newTx   = txSel_e'(busWrData[TXSEL_LSB +: 2]);
  end

  // R3
  no_load_when_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> !strb.load);

  // R10
  no_load_off_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != REG_ADDR) |-> !strb.load);

endmodule

// File: rtl/can_test_dp.sv
module can_test_dp
  import can_test_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LOOP_BIT    = 4,
  parameter int TXSEL_LSB   = 5,
  parameter int RX_BIT      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic              rdHit,
  input  logic              coreTx,
  input  logic              samplePt,
  input  logic              rxPin,
  output logic [DATA_W-1:0] rdData,
  output logic              txPin,
  output logic              coreRx
);

  logic                   loopQ;
  txSel_e                 txSelQ;
  logic [SYNC_STAGES-1:0] rxStage;
  logic                   rxSync;
  logic                   txNext;

  // test fields: clear has priority over load
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      loopQ  <= 1'b0;
      txSelQ <= TX_CORE;
    end else if (strb.load) begin
      loopQ  <= strb.newLoop;
      txSelQ <= strb.newTx;
    end
  end

  // receive synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) rxStage[0] <= 1'b1;
    else       rxStage[0] <= rxPin;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) rxStage[i] <= 1'b1;
        else       rxStage[i] <= rxStage[i-1];
      end
      // R8
      sync_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> rxStage[i] == $past(rxStage[i-1]));
    end
  endgenerate

  assign rxSync = rxStage[SYNC_STAGES-1];

  // transmit pin mux
  always_comb begin
    unique case (txSelQ)
      TX_CORE:   txNext = coreTx;
      TX_SAMPLE: txNext = ~samplePt;
      TX_DOM:    txNext = 1'b0;
      TX_REC:    txNext = 1'b1;
      default:   txNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) txPin <= 1'b1;
    else       txPin <= txNext;
  end

  assign coreRx = loopQ ? coreTx : rxSync;

  always_comb begin
    rdData = '0;
    if (rdHit) begin
      rdData[LOOP_BIT]         = loopQ;
      rdData[TXSEL_LSB +: 2]   = txSelQ;
      rdData[RX_BIT]           = rxSync;
    end
  end

  // R4
  clear_on_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (!loopQ && txSelQ == TX_CORE));

  // R6
  sample_dom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txSelQ == TX_SAMPLE && samplePt && !strb.clrAll && !strb.load) |=> !txPin);

  // R7
  force_dom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txSelQ == TX_DOM) |=> !txPin);

  // R7
  force_rec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txSelQ == TX_REC) |=> txPin);

  // R9
  loop_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopQ |-> (coreRx == coreTx));

endmodule

// File: rtl/can_test_reg.sv
module can_test_reg
  import can_test_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
  parameter int LOOP_BIT    = 4,
  parameter int TXSEL_LSB   = 5,
  parameter int RX_BIT      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              coreTx,
  input  logic              samplePt,
  input  logic              rxPin,
  output logic              txPin,
  output logic              coreRx
);

  regStrobe_t strb;
  logic       rdHit;

  can_test_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .LOOP_BIT(LOOP_BIT), .TXSEL_LSB(TXSEL_LSB)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .testEn(testEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .strb(strb), .rdHit(rdHit)
  );

  can_test_dp #(
    .DATA_W(DATA_W), .LOOP_BIT(LOOP_BIT), .TXSEL_LSB(TXSEL_LSB),
    .RX_BIT(RX_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdHit(rdHit),
    .coreTx(coreTx), .samplePt(samplePt), .rxPin(rxPin),
    .rdData(busRdData), .txPin(txPin), .coreRx(coreRx)
  );

endmodule

// File: tb/can_test_reg_tb.sv
module can_test_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RA = 8'h10;

  // {testEn, addr, data, expected bits 6:4}
  localparam logic [43:0] VEC [0:7] = '{
    {1'b1, 8'h10, 32'h0000_0010, 3'b001},
    {1'b1, 8'h10, 32'h0000_0060, 3'b110},
    {1'b1, 8'h10, 32'hFFFF_FFFF, 3'b111},
    {1'b1, 8'h14, 32'h0000_0000, 3'b111},
    {1'b1, 8'h10, 32'hFFFF_FF8F, 3'b000},
    {1'b1, 8'h10, 32'h0000_0020, 3'b010},
    {1'b0, 8'h10, 32'h0000_0070, 3'b000},
    {1'b0, 8'h10, 32'h0000_0050, 3'b000}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        testEn = 0, busWrEn = 0, coreTx = 1, samplePt = 0, rxPin = 1;
  logic [7:0]  busAddr = RA;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic        txPin, coreRx;
  int          checks = 0, errors = 0;
  bit          done = 0;

  can_test_reg dut_i (
    .clk(clk), .rstN(rstN), .testEn(testEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .coreTx(coreTx), .samplePt(samplePt), .rxPin(rxPin),
    .txPin(txPin), .coreRx(coreRx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic te, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    testEn = te; busWrEn = 1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 0; busAddr = RA;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fields", {29'd0, busRdData[6:4]}, 32'd0);
    coreTx = 0; @(negedge clk);
    chk("R1 txPin core", {31'd0, txPin}, 32'd0);
    coreTx = 1; @(negedge clk);

    // register access table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][43], VEC[i][42:35], VEC[i][34:3]);
      testEn = VEC[i][43];
      chk((i >= 6) ? "R3 locked write" : (i == 3 || i == 4) ? "R10 ignored bits/addr" : "R2 field map",
          {29'd0, busRdData[6:4]}, {29'd0, VEC[i][2:0]});
      chk("R2 reserved zero", {busRdData[31:8], busRdData[3:0]}, 28'd0);
    end

    // R4 clear on test-enable drop
    wr(1, RA, 32'h70);
    chk("R4 preset", {29'd0, busRdData[6:4]}, 32'h7);
    testEn = 0; @(negedge clk);
    chk("R4 cleared", {29'd0, busRdData[6:4]}, 32'd0);

    // R2 other address reads zero
    wr(1, RA, 32'h70);
    busAddr = 8'h14; #1;
    chk("R2 off-address read", busRdData, 32'd0);
    busAddr = RA;

    // R5 core pass-through
    wr(1, RA, 32'h00);
    coreTx = 0; @(negedge clk);
    chk("R5 core 0", {31'd0, txPin}, 32'd0);
    coreTx = 1; @(negedge clk);
    chk("R5 core 1", {31'd0, txPin}, 32'd1);

    // R6 sample point
    wr(1, RA, 32'h20);
    chk("R6 idle rec", {31'd0, txPin}, 32'd1);
    samplePt = 1; @(negedge clk);
    samplePt = 0;
    chk("R6 pulse dom", {31'd0, txPin}, 32'd0);
    @(negedge clk);
    chk("R6 after rec", {31'd0, txPin}, 32'd1);

    // R7 forced levels
    wr(1, RA, 32'h40);
    coreTx = 1; @(negedge clk);
    chk("R7 dominant", {31'd0, txPin}, 32'd0);
    wr(1, RA, 32'h60);
    coreTx = 0; @(negedge clk);
    chk("R7 recessive", {31'd0, txPin}, 32'd1);
    coreTx = 1;

    // R8 receive synchronizer
    wr(1, RA, 32'h00);
    rxPin = 0; @(negedge clk);
    chk("R8 one clock", {31'd0, busRdData[7]}, 32'd1);
    @(negedge clk);
    chk("R8 two clocks", {31'd0, busRdData[7]}, 32'd0);
    chk("R9 no loop", {31'd0, coreRx}, 32'd0);

    // R9 loopback
    wr(1, RA, 32'h10);
    coreTx = 1; #1;
    chk("R9 loop 1", {31'd0, coreRx}, 32'd1);
    coreTx = 0; rxPin = 1; #1;
    chk("R9 loop 0", {31'd0, coreRx}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 loop ignores pin", {31'd0, coreRx}, 32'd0);
    testEn = 0; @(negedge clk);
    chk("R9 loop off", {31'd0, coreRx}, 32'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule